// File: doc/BRIEF.md
# Serial-Bus DAC Code Register Receiver

This block is the digital front end of a 12-bit voltage-output converter. It listens on a two-wire I2C bus as a receive-only slave and oversamples both lines with a fast system clock. Each line passes through a synchronizer and a glitch filter. The block then finds START, repeated START and STOP conditions and the SCL edges. It matches a 7-bit device address, one bit of which comes from a strap pin, and accepts a stream of 16-bit words. It acknowledges each accepted byte by raising an open-drain enable that pulls SDA low.

Each word is a control/high byte followed by a low byte. The control byte holds a 2-bit power-down selector and the top four code bits. The low byte holds the remaining eight bits. The code and the selector are committed together, with a one-cycle update strobe, only when the acknowledge clock of the low byte ends. An incomplete word therefore never disturbs the analog stage. A master code for the high-speed bus mode is recognised and left unacknowledged. The block then stays quiet until a repeated START brings a fresh address.

Top module: `i2c_dac_slave`

## Requirements
- R1: During and right after reset, `dac_code` is 0, `pd_mode` is 0 (normal operation), `update` is 0 and `sda_oe` is 0.
- R2: An address byte 1,0,0,1,1,0,S,0 (MSB first, S = captured strap) is acknowledged: `sda_oe` is 1 for the whole ninth SCL clock, so the bus reads SDA low. If S differs from the captured strap, the byte is not acknowledged and the following bytes up to the next START are ignored.
- R3: The strap is captured during reset and held. A later change on `addr_strap` without reset does not change which address is acknowledged.
- R4: An address byte with its last bit (R/W) at 1 is not acknowledged, and nothing is committed after it.
- R5: The address byte 8'h90 is acknowledged whatever the strap value.
- R6: Control byte bits [5:4] become `pd_mode`, with the encodings 00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground and 11 high impedance. Control byte bits [3:0] become `dac_code[11:8]`. The low byte becomes `dac_code[7:0]`. Control byte bits [7:6] are ignored.
- R7: `dac_code` and `pd_mode` change only on the falling SCL edge that ends the acknowledge clock of a low byte, where `update` pulses for one cycle. They keep their old value after the control byte alone.
- R8: After an accepted address, every data byte is acknowledged. Control/low pairs repeat until STOP, and each complete pair commits once.
- R9: A repeated START returns the block to address reception, so a new address and new words are accepted in the same bus session.
- R10: A byte 00001xxx right after START is not acknowledged. The bytes after it are ignored, even a matching address, until a repeated START followed by a matching address byte.
- R11: A pulse shorter than FILT_LEN system clocks on SCL or SDA is ignored: it adds no bit and creates no START or STOP.
- R12: A START or STOP in the middle of a word aborts that word and leaves `dac_code`, `pd_mode` and the update count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| addr_strap | input | 1 | Device-select strap, compared with address bit 1 |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| dac_code | output | 12 | Committed converter code |
| pd_mode | output | 2 | Committed power-down selector |
| update | output | 1 | One-cycle strobe when a word commits |

## Verification
The bench goes after these cases:
- A word cut short by a STOP inside the low byte, or by a repeated START after the control byte. A design that commits at the control-byte acknowledge, or as soon as eight low bits arrive, would change the code here.
- A high-speed master code followed by a matching address byte without a repeated START. A design that re-arms address matching without that START would wrongly acknowledge the address.
- A strap change after reset, and the broadcast address. A design that samples the strap live, or compares the broadcast address through the strap bit, would acknowledge the wrong addresses.
- Single-cycle pulses on SCL during the low phase and on SDA during the high phase. A missing filter would add a bit or create a false STOP.

// File: rtl/i2c_dac_pkg.sv
// Shared types and constants of the serial-bus DAC register receiver.
// Assumes: 7-bit addressing, write-only transfers.
package i2c_dac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for START
        ST_ADDR,     // shifting in the address byte
        ST_ADDR_ACK, // driving the address acknowledge
        ST_HI,       // shifting in the control/high byte
        ST_HI_ACK,   // driving the control-byte acknowledge
        ST_LO,       // shifting in the low byte
        ST_LO_ACK,   // driving the low-byte acknowledge, commit at its end
        ST_HOLD      // not addressed: ignore until START/STOP
    } slv_state_t;

    // Fixed upper six address bits; bit 1 is the strap, bit 0 is R/W.
    localparam logic [5:0] DEV_PREFIX = 6'b100110;
    // Broadcast address accepted regardless of the strap.
    localparam logic [7:0] BCAST_ADDR = 8'h90;

    // Filtered-bus events, one cycle wide.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2c_line_filter.sv
// Two-flop synchronizer followed by an agreement filter for one bus line.
// The output follows the input only after FILT_LEN equal synchronized samples.
// Assumes: idle level of the line is high.
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_i};
    end

    // Keep a window of recent synchronized samples.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
    end

    // Change the output only when the whole window agrees.
    always_ff @(posedge clk) begin
        if (!rst_n)            line_o <= 1'b1;
        else if (&hist_q)      line_o <= 1'b1;
        else if (~|hist_q)     line_o <= 1'b0;
    end
endmodule

// File: rtl/i2c_bus_events.sv
// Turns the filtered SCL/SDA levels into START, STOP and SCL edge events.
// Assumes: inputs are already synchronous and glitch-free.
module i2c_bus_events
    import i2c_dac_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode conditions: SDA moving while SCL stays high.
    always_comb begin
        ev.start    = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop     = scl_f & scl_q & ~sda_q & sda_f;
        ev.scl_rise = scl_f & ~scl_q;
        ev.scl_fall = ~scl_f & scl_q;
        ev.sda      = sda_f;
    end
endmodule

// File: rtl/i2c_dac_fsm.sv
// Byte/acknowledge sequencer and the committed code register.
// Receives bits on SCL rise and drives the acknowledge from one SCL fall to the next.
// Commits a word only at the end of the low-byte acknowledge clock.
// Assumes: DATA_W >= 8 and DATA_W - 8 + 2 <= 8 (control byte holds mode + high bits).
module i2c_dac_fsm
    import i2c_dac_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  bus_ev_t           ev,
    output logic              sda_oe,
    output logic [DATA_W-1:0] dac_code,
    output logic [1:0]        pd_mode,
    output logic              update
);
    localparam int HI_W      = DATA_W - 8;
    localparam int CTRL_W    = HI_W + 2;
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    slv_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [7:0]        shreg;
    logic [CTRL_W-1:0] ctrl_q;
    logic              strap_q;
    logic              byte_done;
    logic              addr_hit;

    // A byte is complete when the SCL fall follows its eighth bit.
    assign byte_done = ev.scl_fall && (bit_cnt == CNT_W'(BYTE_BITS));
    // Own address with write direction, or the broadcast address.
    assign addr_hit  = (shreg == {DEV_PREFIX, strap_q, 1'b0}) || (shreg == BCAST_ADDR);

    // Main sequencer: bus conditions first, then byte and acknowledge phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ctrl_q   <= '0;
            sda_oe   <= 1'b0;
            dac_code <= '0;
            pd_mode  <= '0;
            update   <= 1'b0;
            strap_q  <= strap_i;
        end else begin
            update <= 1'b0;
            if (ev.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_HI, ST_LO: begin
                        if (ev.scl_rise && bit_cnt != CNT_W'(BYTE_BITS)) begin
                            shreg   <= {shreg[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                // High-speed master codes and foreign addresses land here unacknowledged.
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state  <= ST_HOLD;
                                end
                            end else if (state == ST_HI) begin
                                ctrl_q <= shreg[CTRL_W-1:0];
                                sda_oe <= 1'b1;
                                state  <= ST_HI_ACK;
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_LO_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_HI;
                    end
                    ST_HI_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_LO;
                    end
                    ST_LO_ACK: if (ev.scl_fall) begin
                        sda_oe   <= 1'b0;
                        dac_code <= {ctrl_q[HI_W-1:0], shreg};
                        pd_mode  <= ctrl_q[CTRL_W-1:HI_W];
                        update   <= 1'b1;
                        state    <= ST_HI;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_dac_slave.sv
// Top of the write-only serial-bus DAC code register receiver.
// Filters both bus lines, decodes bus events and runs the word sequencer.
// Assumes: clk is at least ~16x the SCL bit rate; the SDA pad is open drain.
module i2c_dac_slave #(
    parameter int FILT_LEN = 3,
    parameter int DATA_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_strap,
    output logic              sda_oe,
    output logic [DATA_W-1:0] dac_code,
    output logic [1:0]        pd_mode,
    output logic              update
);
    import i2c_dac_pkg::*;

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    bus_ev_t            ev;

    assign raw_lines = {sda_i, scl_i};

    // One synchronizer/filter per bus line.
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[i]),
            .line_o (filt_lines[i])
        );
    end

    i2c_bus_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_f (filt_lines[0]),
        .sda_f (filt_lines[1]),
        .ev    (ev)
    );

    i2c_dac_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_i  (addr_strap),
        .ev       (ev),
        .sda_oe   (sda_oe),
        .dac_code (dac_code),
        .pd_mode  (pd_mode),
        .update   (update)
    );
endmodule

// File: rtl/i2c_dac_slave_chk.sv
// Protocol checker for i2c_dac_slave, bound to every instance of the top.
// Assumes: the master holds SCL low for longer than the input filter latency.
module i2c_dac_slave_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [DATA_W-1:0] dac_code,
    input logic [1:0]        pd_mode,
    input logic              update
);
    AST_UPDATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> !update); // R7
    AST_COMMIT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((dac_code != $past(dac_code)) || (pd_mode != $past(pd_mode))) |-> update); // R7
    AST_ACK_IN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i); // R2
    AST_RELEASE_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        update |-> !sda_oe); // R8
endmodule

bind i2c_dac_slave i2c_dac_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .dac_code (dac_code),
    .pd_mode  (pd_mode),
    .update   (update)
);

// File: tb/tb_i2c_dac_slave.sv
`timescale 1ns/1ps
module tb_i2c_dac_slave;
    localparam int Q = 16;  // system clocks per SCL phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        strap = 1'b0;
    logic        sda_bus;
    logic        sda_oe;
    logic [11:0] dac_code;
    logic [1:0]  pd_mode;
    logic        update;

    int n_chk = 0;
    int n_fail = 0;
    int upd_cnt = 0;
    int exp_upd = 0;
    logic [11:0] exp_code = '0;
    logic [1:0]  exp_pd = '0;
    logic        cap_strap = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    assign sda_bus = sda_m & ~sda_oe;

    i2c_dac_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_strap(strap), .sda_oe(sda_oe), .dac_code(dac_code),
        .pd_mode(pd_mode), .update(update)
    );

    // Count update strobes seen at the port.
    always @(posedge clk) if (rst_n && update) upd_cnt <= upd_cnt + 1;

    function automatic logic [7:0] hi_byte(logic [1:0] p, logic [11:0] c);
        return {2'b00, p, c[11:8]};
    endfunction

    function automatic logic [7:0] own_addr(logic s, logic rw);
        return {6'b100110, s, rw};
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b, bit glitch);
        sda_m = b;
        tick(Q / 2);
        if (glitch) begin scl_m = 1'b1; tick(1); scl_m = 1'b0; end
        tick(Q / 2);
        scl_m = 1'b1;
        tick(Q / 2);
        if (glitch && b) begin sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(Q / 2 - 1); end
        else tick(Q / 2);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic send_byte(logic [7:0] b, bit glitch, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch);
        sda_m = 1'b1;
        tick(Q);
        scl_m = 1'b1;
        tick(Q / 2);
        ack = ~sda_bus;
        tick(Q / 2);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic do_reset(logic s);
        rst_n = 1'b0; strap = s; tick(6);
        rst_n = 1'b1; cap_strap = s; exp_code = '0; exp_pd = '0;
        tick(4);
    endtask

    task automatic check_regs(string req);
        tick(4);
        chk({req, " code"}, dac_code, exp_code);
        chk({req, " pd"}, pd_mode, exp_pd);
        chk({req, " update count"}, upd_cnt, exp_upd);
    endtask

    // Send one word; commit it in the model if it should be accepted.
    task automatic word(logic [11:0] c, logic [1:0] p, bit accept, bit glitch, string req);
        logic a;
        send_byte(hi_byte(p, c), glitch, a);
        chk({req, " hi ack"}, a, accept);
        send_byte(c[7:0], glitch, a);
        chk({req, " lo ack"}, a, accept);
        if (accept) begin exp_code = c; exp_pd = p; exp_upd++; end
    endtask

    initial begin
        logic a;
        int seed;
        seed = $urandom(32'd2024);
        do_reset(1'b0);
        // R1: reset state
        chk("R1 code", dac_code, 0);
        chk("R1 pd", pd_mode, 0);
        chk("R1 oe", sda_oe, 0);
        chk("R1 update", update, 0);

        // R2/R6/R7: own address, one word, no commit after the control byte alone
        bus_start();
        send_byte(own_addr(1'b0, 1'b0), 0, a); chk("R2 own address ack", a, 1);
        send_byte(hi_byte(2'b01, 12'hA5C), 0, a); chk("R8 hi ack", a, 1);
        tick(4);
        chk("R7 code held after control byte", dac_code, 0);
        chk("R7 no strobe after control byte", upd_cnt, 0);
        send_byte(8'h5C, 0, a); chk("R8 lo ack", a, 1);
        exp_code = 12'hA5C; exp_pd = 2'b01; exp_upd = 1;
        tick(4);
        chk("R7 commit at end of low ack", dac_code, 12'hA5C);
        chk("R6 pd field", pd_mode, 2'b01);
        bus_stop();
        check_regs("R6");

        // R2: wrong strap bit, following bytes ignored
        bus_start();
        send_byte(own_addr(1'b1, 1'b0), 0, a); chk("R2 foreign address nack", a, 0);
        word(12'h123, 2'b10, 0, 0, "R2");
        bus_stop(); check_regs("R2");

        // R4: read direction
        bus_start();
        send_byte(own_addr(1'b0, 1'b1), 0, a); chk("R4 read nack", a, 0);
        word(12'h777, 2'b11, 0, 0, "R4");
        bus_stop(); check_regs("R4");

        // R5/R6: broadcast address, high-impedance mode
        bus_start();
        send_byte(8'h90, 0, a); chk("R5 broadcast ack", a, 1);
        word(12'h3C1, 2'b11, 1, 0, "R5");
        bus_stop(); check_regs("R5");

        // R8: several pairs in one session
        bus_start();
        send_byte(own_addr(1'b0, 1'b0), 0, a); chk("R8 address ack", a, 1);
        word(12'h001, 2'b00, 1, 0, "R8");
        word(12'hFFF, 2'b10, 1, 0, "R8");
        word(12'h800, 2'b00, 1, 0, "R8");
        bus_stop(); check_regs("R8");

        // R9/R12: repeated START after a lone control byte, then a new address
        bus_start();
        send_byte(own_addr(1'b0, 1'b0), 0, a);
        send_byte(hi_byte(2'b11, 12'hBAD), 0, a);
        bus_start();
        check_regs("R12 repeated start after control byte");
        send_byte(8'h90, 0, a); chk("R9 address after repeated start", a, 1);
        word(12'h456, 2'b00, 1, 0, "R9");
        bus_stop(); check_regs("R9");

        // R10: high-speed master code, then an address without repeated START
        bus_start();
        send_byte(8'h0D, 0, a); chk("R10 master code nack", a, 0);
        send_byte(own_addr(1'b0, 1'b0), 0, a); chk("R10 address ignored without Sr", a, 0);
        bus_start();
        send_byte(own_addr(1'b0, 1'b0), 0, a); chk("R10 address after Sr", a, 1);
        word(12'h9E2, 2'b01, 1, 0, "R10");
        bus_stop(); check_regs("R10");

        // R12: STOP inside the low byte, START inside the control byte
        bus_start();
        send_byte(own_addr(1'b0, 1'b0), 0, a);
        send_byte(hi_byte(2'b10, 12'hCCC), 0, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 0);
        bus_stop(); check_regs("R12 stop mid low byte");
        bus_start();
        send_byte(own_addr(1'b0, 1'b0), 0, a);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 0);
        bus_start();
        bus_stop(); check_regs("R12 start mid control byte");

        // R11: one-cycle pulses on SCL (low phase) and SDA (high phase)
        bus_start();
        send_byte(own_addr(1'b0, 1'b0), 1, a); chk("R11 address ack with glitches", a, 1);
        word(12'hB6D, 2'b10, 1, 1, "R11");
        bus_stop(); check_regs("R11");

        // R3: strap captured in reset; a later change has no effect
        do_reset(1'b1);
        chk("R1 code after second reset", dac_code, 0);
        strap = 1'b0;
        bus_start();
        send_byte(own_addr(1'b0, 1'b0), 0, a); chk("R3 live strap ignored", a, 0);
        bus_start();
        send_byte(own_addr(1'b1, 1'b0), 0, a); chk("R3 captured strap ack", a, 1);
        word(12'h2F0, 2'b00, 1, 0, "R3");
        bus_stop(); check_regs("R3");

        // Random sessions mixing accepted and rejected addresses
        for (int t = 0; t < 20; t++) begin
            int kind = $urandom_range(0, 3);
            int nw = $urandom_range(1, 3);
            bit acc = (kind < 2);
            logic [7:0] ab;
            case (kind)
                0: ab = own_addr(cap_strap, 1'b0);
                1: ab = 8'h90;
                2: ab = own_addr(~cap_strap, 1'b0);
                default: ab = own_addr(cap_strap, 1'b1);
            endcase
            bus_start();
            send_byte(ab, 0, a); chk("R2 random address ack", a, acc);
            for (int w = 0; w < nw; w++)
                word(12'($urandom_range(0, 4095)), 2'($urandom_range(0, 3)), acc, 0, "R8 random");
            bus_stop(); check_regs("R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule